// File: doc/BRIEF.md
# Presettable Cascadable Down Counter Stage

This block is a four-bit down counter stage that works on a fast system clock. The slow count inputs `tick` and `inhibit` come from outside that clock and are sampled there. A count event is one of two things. The first is a rising edge on `tick` while `inhibit` is low. The second is a falling edge on `inhibit` while `tick` is high, so `inhibit` can serve as a second clock that counts on its falling edge. Each event moves the count down by one. The parameter `BINARY` chooses the range at build time: 9 down to 0 (decade) or 15 down to 0 (binary). In both, a step from zero wraps to the top value.

Two inputs act at once, without waiting for the system clock. `clear` forces the count to zero and overrides every other input. `load` copies the parallel `preset` value into the count. The `zero` output is high only while the count is zero and the `cascade` input is high. Connecting `zero` back to `load` makes the stage divide by N: the preset value N is reloaded the moment the count reaches zero. Stages can be chained through `cascade` with no extra gates.

Inside the block, a step decoder sorts the two edge strobes into four named kinds:
- STEP_IDLE: no event.
- STEP_TICK: a qualified `tick` rise.
- STEP_GATE: a qualified `inhibit` fall.
- STEP_BOTH: both arrive in one cycle.

Any kind other than STEP_IDLE moves the count register from its present value to the next value down, or from zero to the top value. `clear` moves it to zero and `load` moves it to `preset`, at any time.

Top module: `pdc_stage`

## Requirements
- R1: While `clear` is high, the count is 0 at once (no system clock edge needed), even if `load` is also high.
- R2: With `clear` low, `load` high copies `preset` into the count at once. It also wins over any count event in the same cycle.
- R3: With `clear` and `load` low, a rising edge on `tick` while `inhibit` is low lowers the count by one. The new count appears on the third system clock edge after the input changes.
- R4: With `clear` and `load` low, a falling edge on `inhibit` while `tick` is high lowers the count by one.
- R5: A `tick` edge while `inhibit` is high leaves the count unchanged. A falling `tick` edge or a rising `inhibit` edge also leaves it unchanged.
- R6: `zero` is 1 exactly when the count is 0 and `cascade` is 1. Otherwise it is 0.
- R7: A count event at 0 wraps to 9 when `BINARY`=0 and to 15 when `BINARY`=1. In decade mode, a preset of 10 to 15 steps down one at a time to 9 and carries on from there.
- R8: With `zero` fed back into `load` and `cascade` high, a preset of N (1 to 9 in decade mode, 1 to 15 in binary mode) returns the count to N after every N count events.
- R9: A qualifying `tick` rise and a qualifying `inhibit` fall that land in the same system cycle lower the count by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples `tick` and `inhibit` |
| clear | input | 1 | Asynchronous clear to 0, highest priority |
| load | input | 1 | Asynchronous parallel load of `preset` |
| preset | input | 4 | Value copied in by `load` |
| tick | input | 1 | Count input, active on its rising edge |
| inhibit | input | 1 | Blocks `tick` while high; counts on its falling edge |
| cascade | input | 1 | Enables the `zero` output |
| count | output | 4 | Present count |
| zero | output | 1 | High when count is 0 and `cascade` is high |

## Verification
Two actions can fall in the same system cycle: a count event and an asynchronous load. In the first case the bench holds `load` high and raises `tick`. The count must still show the preset value after the strobe has passed, because the load wins. In the second case the bench changes `tick` and `inhibit` on the same negative edge so that both edges qualify together. The count must then drop by exactly one.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        STEP_IDLE,
        STEP_TICK,
        STEP_GATE,
        STEP_BOTH
    } step_t;

    function automatic logic [CNT_W-1:0] next_down(input logic [CNT_W-1:0] v,
                                                   input int unsigned top);
        if (v == '0)
            return CNT_W'(top);
        return v - 1'b1;
    endfunction
endpackage

// File: rtl/pdc_edge_sync.sv
module pdc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic raw,
    output logic lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        chain[0] <= raw;
    end

    generate
        for (genvar g = 1; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign lvl  = chain[STAGES-1];
    assign rise = chain[STAGES-1] & ~chain[STAGES];
    assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/pdc_step_decode.sv
module pdc_step_decode
    import pdc_pkg::*;
(
    input  logic  tick_lvl,
    input  logic  tick_rise,
    input  logic  gate_lvl,
    input  logic  gate_fall,
    output step_t kind,
    output logic  step
);
    logic tick_ok;
    logic gate_ok;

    always_comb begin
        tick_ok = tick_rise & ~gate_lvl;
        gate_ok = gate_fall & tick_lvl;
        unique case ({tick_ok, gate_ok})
            2'b00:   kind = STEP_IDLE;
            2'b10:   kind = STEP_TICK;
            2'b01:   kind = STEP_GATE;
            default: kind = STEP_BOTH;
        endcase
    end

    always_comb begin
        unique case (kind)
            STEP_IDLE: step = 1'b0;
            STEP_TICK,
            STEP_GATE,
            STEP_BOTH: step = 1'b1;
            default:   step = 1'b0;
        endcase
    end
endmodule

// File: rtl/pdc_count_reg.sv
module pdc_count_reg
    import pdc_pkg::*;
#(
    parameter int unsigned TOP = 9
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    input  logic             step,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or posedge clear or posedge load) begin
        if (clear)
            count <= '0;
        else if (load)
            count <= preset;
        else if (step)
            count <= next_down(count, TOP);
    end
endmodule

// File: rtl/pdc_stage.sv
module pdc_stage
    import pdc_pkg::*;
#(
    parameter bit BINARY   = 1'b0,
    parameter int SYNC_LEN = 2
) (
    input  logic             clk,
    input  logic             clear,
    input  logic             load,
    input  logic [CNT_W-1:0] preset,
    input  logic             tick,
    input  logic             inhibit,
    input  logic             cascade,
    output logic [CNT_W-1:0] count,
    output logic             zero
);
    localparam int unsigned TOP = BINARY ? (1 << CNT_W) - 1 : 9;

    logic  tick_lvl, tick_rise, tick_fall;
    logic  gate_lvl, gate_rise, gate_fall;
    step_t kind;
    logic  step;

    pdc_edge_sync #(.STAGES(SYNC_LEN)) u_tick_sync (
        .clk (clk),
        .raw (tick),
        .lvl (tick_lvl),
        .rise(tick_rise),
        .fall(tick_fall)
    );

    pdc_edge_sync #(.STAGES(SYNC_LEN)) u_gate_sync (
        .clk (clk),
        .raw (inhibit),
        .lvl (gate_lvl),
        .rise(gate_rise),
        .fall(gate_fall)
    );

    pdc_step_decode u_decode (
        .tick_lvl (tick_lvl),
        .tick_rise(tick_rise),
        .gate_lvl (gate_lvl),
        .gate_fall(gate_fall),
        .kind     (kind),
        .step     (step)
    );

    pdc_count_reg #(.TOP(TOP)) u_count (
        .clk   (clk),
        .clear (clear),
        .load  (load),
        .preset(preset),
        .step  (step),
        .count (count)
    );

    assign zero = (count == '0) & cascade;
endmodule

// File: rtl/pdc_stage_chk.sv
module pdc_stage_chk
    import pdc_pkg::*;
#(
    parameter int unsigned TOP = 9
) (
    input logic             clk,
    input logic             clear,
    input logic             load,
    input logic [CNT_W-1:0] preset,
    input logic             step,
    input logic             cascade,
    input logic [CNT_W-1:0] count,
    input logic             zero
);
    p_clear_zero_r1: assert property (@(posedge clk) clear |-> count == '0);

    p_load_copy_r2: assert property (@(posedge clk) disable iff (clear)
        load |=> (load || count == $past(preset)));

    p_step_down_r3: assert property (@(posedge clk) disable iff (clear)
        (step && !load) |=> (load || count == next_down($past(count), TOP)
                             || next_down($past(count), TOP) == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (clear)
        (!step && !load) |=> (load || $stable(count)));

    p_zero_gate_r6: assert property (@(posedge clk) disable iff (clear)
        zero |-> (count == '0 && cascade));

    p_zero_off_r6: assert property (@(posedge clk) disable iff (clear)
        !cascade |-> !zero);
endmodule

bind pdc_stage pdc_stage_chk #(.TOP(TOP)) u_chk (
    .clk    (clk),
    .clear  (clear),
    .load   (load),
    .preset (preset),
    .step   (step),
    .cascade(cascade),
    .count  (count),
    .zero   (zero)
);

// File: tb/test_pdc_stage.sv
module test_pdc_stage;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       clear = 1'b1;
    logic       man_load = 1'b0;
    logic       loop_en = 1'b0;
    logic [3:0] preset = 4'd0;
    logic       tick = 1'b0;
    logic       inhibit = 1'b0;
    logic       cascade = 1'b1;
    logic [3:0] cnt_d, cnt_b;
    logic       zero_d, zero_b;
    logic       load_d, load_b;

    int nchk = 0;
    int nerr = 0;
    logic [3:0] m_d = 4'd0;
    logic [3:0] m_b = 4'd0;

    always #(CLK_P/2) clk = ~clk;

    assign load_d = man_load | (loop_en & zero_d);
    assign load_b = man_load | (loop_en & zero_b);

    pdc_stage #(.BINARY(1'b0)) i_pdc_stage (
        .clk(clk), .clear(clear), .load(load_d), .preset(preset),
        .tick(tick), .inhibit(inhibit), .cascade(cascade),
        .count(cnt_d), .zero(zero_d)
    );

    pdc_stage #(.BINARY(1'b1)) i_pdc_stage_bin (
        .clk(clk), .clear(clear), .load(load_b), .preset(preset),
        .tick(tick), .inhibit(inhibit), .cascade(cascade),
        .count(cnt_b), .zero(zero_b)
    );

    function automatic logic [3:0] down(input logic [3:0] v, input int top);
        return (v == 4'd0) ? 4'(top) : v - 4'd1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_both(input string req);
        check({req, " decade"}, cnt_d, m_d);
        check({req, " binary"}, cnt_b, m_b);
    endtask

    task automatic model_event();
        m_d = down(m_d, 9);
        m_b = down(m_b, 15);
        if (loop_en && cascade) begin
            if (m_d == 4'd0) m_d = preset;
            if (m_b == 4'd0) m_b = preset;
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_tick(input logic v);
        @(negedge clk);
        if (v && !tick && !inhibit && !man_load) model_event();
        tick = v;
        settle();
    endtask

    task automatic set_inh(input logic v);
        @(negedge clk);
        if (!v && inhibit && tick && !man_load) model_event();
        inhibit = v;
        settle();
    endtask

    task automatic do_load(input logic [3:0] v);
        @(negedge clk);
        preset = v;
        man_load = 1'b1;
        #1;
        m_d = v;
        m_b = v;
        check_both("R2 async load");
        @(negedge clk);
        man_load = 1'b0;
        settle();
    endtask

    task automatic t_reset();
        #1;
        check_both("R1 reset state");
        check("R6 zero at reset", zero_d, 1);
        @(negedge clk);
        preset = 4'd6;
        man_load = 1'b1;
        #1;
        check_both("R1 clear over load");
        @(negedge clk);
        clear = 1'b0;
        settle();
        man_load = 1'b0;
        m_d = 4'd6;
        m_b = 4'd6;
        settle();
        check_both("R2 load after clear");
        @(negedge clk);
        clear = 1'b1;
        #1;
        m_d = 4'd0;
        m_b = 4'd0;
        check_both("R1 async clear");
        @(negedge clk);
        clear = 1'b0;
        settle();
    endtask

    task automatic t_tick();
        do_load(4'd7);
        @(negedge clk);
        tick = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_both("R3 not before third edge");
        @(negedge clk);
        m_d = 4'd6;
        m_b = 4'd6;
        check_both("R3 tick rise");
        set_tick(1'b0);
        check_both("R5 tick fall ignored");
    endtask

    task automatic t_gate();
        set_tick(1'b1);
        set_inh(1'b1);
        check_both("R5 inhibit rise ignored");
        set_inh(1'b0);
        check_both("R4 inhibit fall with tick high");
        set_tick(1'b0);
        set_inh(1'b1);
        set_inh(1'b0);
        check_both("R4 inhibit fall with tick low ignored");
    endtask

    task automatic t_block();
        set_inh(1'b1);
        set_tick(1'b1);
        check_both("R5 tick rise blocked");
        set_tick(1'b0);
        check_both("R5 tick fall blocked");
        set_inh(1'b0);
    endtask

    task automatic t_wrap();
        do_load(4'd0);
        set_tick(1'b1);
        set_tick(1'b0);
        check_both("R7 wrap from zero");
        do_load(4'd12);
        for (int i = 0; i < 4; i++) begin
            set_tick(1'b1);
            set_tick(1'b0);
            check_both("R7 high preset descent");
        end
    endtask

    task automatic t_zero();
        do_load(4'd0);
        cascade = 1'b0;
        #1;
        check("R6 zero gated off", zero_d, 0);
        cascade = 1'b1;
        #1;
        check("R6 zero on", zero_d, 1);
        do_load(4'd3);
        check("R6 zero low on nonzero", zero_b, 0);
    endtask

    task automatic t_divide(input int n);
        loop_en = 1'b1;
        cascade = 1'b1;
        do_load(4'(n));
        for (int i = 0; i < n; i++) begin
            set_tick(1'b1);
            set_tick(1'b0);
            if (n <= 9) check("R8 divide decade", cnt_d, m_d);
            check("R8 divide binary", cnt_b, m_b);
        end
        if (n <= 9) check("R8 period decade", cnt_d, n);
        check("R8 period binary", cnt_b, n);
        loop_en = 1'b0;
    endtask

    task automatic t_both();
        do_load(4'd5);
        set_inh(1'b1);
        @(negedge clk);
        tick = 1'b1;
        inhibit = 1'b0;
        m_d = 4'd4;
        m_b = 4'd4;
        settle();
        check_both("R9 coincident edges single step");
        set_tick(1'b0);
    endtask

    task automatic t_load_wins();
        @(negedge clk);
        preset = 4'd8;
        man_load = 1'b1;
        m_d = 4'd8;
        m_b = 4'd8;
        @(negedge clk);
        tick = 1'b1;
        settle();
        check_both("R2 load over step");
        man_load = 1'b0;
        set_tick(1'b0);
        check_both("R2 after load release");
    endtask

    logic done = 1'b0;

    initial begin
        t_reset();
        t_tick();
        t_gate();
        t_block();
        t_wrap();
        t_zero();
        for (int n = 1; n <= 15; n++) t_divide(n);
        t_both();
        t_load_wins();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule